// File: doc/BRIEF.md
# NOR Flash Command Interpreter

This block is a synchronous model of the command front end of a parallel NOR flash. A host reaches it through a simple bus with an address, write data, a byte count, a write strobe, a read strobe and registered read data. The bus is 1, 2 or 4 bytes wide. The first data byte of each write is treated as a command. The command moves a state machine that decides what later reads return: array contents, identifier codes, the status byte, or bytes of a self-describing query table.

The storage array is small and internal. A single-word program can only clear bits. A block erase sets a whole erase block back to all ones. Protection commands are recognised, but they lock nothing.

Bus addresses are first reduced modulo the device size. For a wide port they are then divided by the port width to form the word index that command and table decoding use. Read data appears one clock after the read strobe is sampled.

Top module: `nor_cmd_front`

## Requirements
- R1: After reset the machine is in read-array mode, the status byte is 0x80 (bit 7 device-ready, bit 5 erase error, bit 4 program error), and every array byte reads 0xFF.
- R2: A write whose `wr_size` (byte count 1, 2 or 4) differs from the port width changes neither the state, the status nor the array.
- R3: The bus address is reduced to the low DEV_AW bits to form a byte offset. The word index is that offset shifted right by 1 for a 2-byte port and by 2 for a 4-byte port. Array accesses use the byte offset, and every command and table decode uses the word index.
- R4: After a program command (0x40 or 0x10), the next correctly sized write ANDs each data byte into the array at the byte offset, so bits only go from 1 to 0. The machine then enters status mode. This holds even when the data byte would otherwise be a command.
- R5: Outside the program-pending state, command 0xFF or 0xF0 returns the machine to read-array mode.
- R6: From read-array or identifier mode, command 0x98 enters query mode only when the word index is 0x55. At any other index the command is absorbed and the mode stays as it was. Command 0x90 enters identifier mode.
- R7: In identifier mode, reads return 16-bit little-endian values by word index: 0 gives the manufacturer code (0x0089 by default), 1 gives 0x00AD, 2 gives 0, 5 gives 0x8000, and any other index gives 0. A 1-byte port returns the low byte.
- R8: Command 0x20 enters erase mode. A following 0xD0 resets the addressed 64-byte block to 0xFF and clears status bits 5 and 4. Any other value sets both bits and leaves the array unchanged. In both cases the machine then enters status mode.
- R9: Command 0x60 enters protect mode. A following 0x01, 0xD0 or 0x2F is accepted with no effect. Any other value sets status bits 5 and 4. In both cases the machine then enters status mode.
- R10: Command 0x50 from read-array or identifier mode sets the status byte to 0x80 and leaves the mode unchanged.
- R11: In status or erase mode a read returns the status byte in the low lane, with the upper lanes zero.
- R12: In query mode, word indices 0x10 to 0x32 return table bytes in the low lane, with the upper lanes zero. The table holds 'Q','R','Y', the command set id (0x0001), zeros up to entry 25, entry 25 = log2 of the device size, entry 30 = one erase region, then the region count minus one and the block size divided by 256, each as 16-bit little-endian. Indices outside that range read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte address |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 3 | Byte count of the write |
| wr_data | input | 8*BUS_BYTES | Write data; low byte is the command |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8*BUS_BYTES | Read data, valid the cycle after `rd_en` |

## Verification
The hardest cases to reach are the ones that depend on command history rather than on a single write. A query command at the wrong word index must leave identifier mode intact. An error left by a failed erase must be cleared by a later successful confirm. The stimulus therefore chains commands deliberately: it first forces the error bits, then exits through a reset command, then re-enters erase and confirms on a different block. It also reads back both the untouched block and the erased one. A program-pending write carrying 0xFF checks that data takes precedence over the reset command.

// File: rtl/nor_cmd_front.sv
module nor_cmd_front #(
  parameter int BUS_BYTES = 2,
  parameter int AW        = 16,
  parameter int DEV_AW    = 8,
  parameter int BLK_AW    = 6,
  parameter logic [15:0] MFR_CODE = 16'h0089,
  parameter logic [15:0] SET_ID   = 16'h0001
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          bus_addr,
  input  logic                   wr_en,
  input  logic [2:0]             wr_size,
  input  logic [8*BUS_BYTES-1:0] wr_data,
  input  logic                   rd_en,
  output logic [8*BUS_BYTES-1:0] rd_data
);
  localparam int DW      = 8 * BUS_BYTES;
  localparam int SH      = (BUS_BYTES == 4) ? 2 : (BUS_BYTES == 2) ? 1 : 0;
  localparam int DEV_N   = 1 << DEV_AW;
  localparam int NBLK    = DEV_N >> BLK_AW;
  localparam int BLK_PG  = (1 << BLK_AW) / 256;
  localparam int TBL_LEN = 35;
  localparam logic [7:0] TBL_BASE = 8'h10;

  typedef enum logic [2:0] {S_READ, S_IDENT, S_QUERY, S_PROT, S_STAT, S_ERASE, S_PROG} st_t;

  st_t                st_q;
  logic [7:0]         status_q;
  logic [7:0]         mem [DEV_N];
  logic [DEV_AW-1:0]  off;
  logic [DEV_AW-1:0]  widx;
  logic [7:0]         cmd;
  logic               wr_ok;
  logic [31:0]        rv;

  assign off   = bus_addr[DEV_AW-1:0];
  assign widx  = off >> SH;
  assign cmd   = wr_data[7:0];
  assign wr_ok = wr_en && (wr_size == 3'(BUS_BYTES));

  function automatic logic [7:0] qbyte(input int i);
    case (i)
      0:  qbyte = 8'h51;
      1:  qbyte = 8'h52;
      2:  qbyte = 8'h59;
      3:  qbyte = SET_ID[7:0];
      4:  qbyte = SET_ID[15:8];
      25: qbyte = 8'(DEV_AW);
      30: qbyte = 8'd1;
      31: qbyte = 8'(NBLK - 1);
      32: qbyte = 8'((NBLK - 1) >> 8);
      33: qbyte = 8'(BLK_PG);
      34: qbyte = 8'(BLK_PG >> 8);
      default: qbyte = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_READ;
      status_q <= 8'h80;
      for (int j = 0; j < DEV_N; j++) mem[j] <= 8'hFF;
    end else if (wr_ok) begin
      if (st_q == S_PROG) begin
        for (int i = 0; i < BUS_BYTES; i++)
          mem[off + DEV_AW'(i)] <= mem[off + DEV_AW'(i)] & wr_data[8*i +: 8];
        st_q <= S_STAT;
      end else if (cmd == 8'hFF || cmd == 8'hF0) begin
        st_q <= S_READ;
      end else begin
        case (st_q)
          S_READ, S_IDENT: begin
            case (cmd)
              8'h98: if (widx == DEV_AW'(8'h55)) st_q <= S_QUERY;
              8'h90: st_q <= S_IDENT;
              8'h20: st_q <= S_ERASE;
              8'h40, 8'h10: st_q <= S_PROG;
              8'h50: status_q <= 8'h80;
              8'h60: st_q <= S_PROT;
              default: ;
            endcase
          end
          S_ERASE: begin
            if (cmd == 8'hD0) begin
              for (int j = 0; j < DEV_N; j++)
                if ((j >> BLK_AW) == (int'(off) >> BLK_AW)) mem[j] <= 8'hFF;
              status_q <= status_q & 8'hCF;
            end else begin
              status_q <= status_q | 8'h30;
            end
            st_q <= S_STAT;
          end
          S_PROT: begin
            if (!(cmd == 8'h01 || cmd == 8'hD0 || cmd == 8'h2F))
              status_q <= status_q | 8'h30;
            st_q <= S_STAT;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rv = '0;
    case (st_q)
      S_READ:
        for (int i = 0; i < BUS_BYTES; i++) rv[8*i +: 8] = mem[off + DEV_AW'(i)];
      S_STAT, S_ERASE: rv[7:0] = status_q;
      S_IDENT:
        case (int'(widx))
          0: rv[15:0] = MFR_CODE;
          1: rv[15:0] = 16'h00AD;
          5: rv[15:0] = 16'h8000;
          default: rv = '0;
        endcase
      S_QUERY:
        if (int'(widx) >= int'(TBL_BASE) && int'(widx) < int'(TBL_BASE) + TBL_LEN)
          rv[7:0] = qbyte(int'(widx) - int'(TBL_BASE));
      default: rv = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= rv[DW-1:0];
  end

  AST_BAD_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok) |=> ($stable(st_q) && $stable(status_q)));  // R2
  AST_PROG_TO_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && st_q == S_PROG) |=> st_q == S_STAT);  // R4
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && st_q != S_PROG && (cmd == 8'hFF || cmd == 8'hF0)) |=> st_q == S_READ);  // R5
  AST_QUERY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && (st_q == S_READ || st_q == S_IDENT) && cmd == 8'h98 && widx != DEV_AW'(8'h55))
    |=> $stable(st_q));  // R6
  AST_ERASE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && st_q == S_ERASE && cmd != 8'hFF && cmd != 8'hF0) |=> st_q == S_STAT);  // R8
  AST_CLR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && (st_q == S_READ || st_q == S_IDENT) && cmd == 8'h50) |=> (status_q == 8'h80 && $stable(st_q)));  // R10
endmodule

// File: tb/nor_cmd_front_bench.sv
module nor_cmd_front_bench;
  localparam int PERIOD = 10;
  localparam int BB = 2;
  localparam int DW = 8 * BB;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [15:0] bus_addr = '0;
  logic [2:0]  wr_size = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;

  int checks = 0, failures = 0;
  int m_st;
  logic [7:0] m_status;
  logic [7:0] m_mem [256];

  always #(PERIOD/2) clk = ~clk;

  nor_cmd_front u_nor_cmd_front (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_size(wr_size), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data));

  function automatic logic [7:0] m_tbl(input int i);
    logic [7:0] t [35];
    foreach (t[k]) t[k] = 8'h00;
    t[0] = "Q"; t[1] = "R"; t[2] = "Y"; t[3] = 8'h01; t[25] = 8'd8; t[30] = 8'd1; t[31] = 8'd3;
    return t[i];
  endfunction

  function automatic logic [DW-1:0] m_read(input int a);
    int off = a % 256;
    int w = off / BB;
    logic [DW-1:0] r = '0;
    case (m_st)
      0: for (int i = 0; i < BB; i++) r[8*i +: 8] = m_mem[(off + i) % 256];
      4, 5: r[7:0] = m_status;
      1: if (w == 0) r = 16'h0089; else if (w == 1) r = 16'h00AD; else if (w == 5) r = 16'h8000;
      2: if (w >= 16 && w < 51) r[7:0] = m_tbl(w - 16);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic m_write(input int a, input logic [DW-1:0] d, input int sz);
    int off = a % 256;
    int w = off / BB;
    logic [7:0] c = d[7:0];
    if (sz != BB) return;
    if (m_st == 6) begin
      for (int i = 0; i < BB; i++) m_mem[(off + i) % 256] &= d[8*i +: 8];
      m_st = 4; return;
    end
    if (c == 8'hFF || c == 8'hF0) begin m_st = 0; return; end
    case (m_st)
      0, 1: case (c)
        8'h98: if (w == 8'h55) m_st = 2;
        8'h90: m_st = 1;
        8'h20: m_st = 5;
        8'h40, 8'h10: m_st = 6;
        8'h50: m_status = 8'h80;
        8'h60: m_st = 3;
        default: ;
      endcase
      5: begin
        if (c == 8'hD0) begin
          for (int j = 0; j < 256; j++) if (j / 64 == off / 64) m_mem[j] = 8'hFF;
          m_status &= 8'hCF;
        end else m_status |= 8'h30;
        m_st = 4;
      end
      3: begin
        if (!(c == 8'h01 || c == 8'hD0 || c == 8'h2F)) m_status |= 8'h30;
        m_st = 4;
      end
      default: ;
    endcase
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input int sz = BB);
    @(negedge clk);
    bus_addr = 16'(a); wr_data = d; wr_size = 3'(sz); wr_en = 1;
    m_write(a, d, sz);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, input string req);
    logic [DW-1:0] exp;
    @(negedge clk);
    bus_addr = 16'(a); rd_en = 1;
    exp = m_read(a);
    @(negedge clk);
    rd_en = 0;
    checks++;
    if (rd_data !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rd_data, exp);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_st = 0; m_status = 8'h80;
    foreach (m_mem[k]) m_mem[k] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, "R1"); rd(8'hFE, "R1");
    wr(0, 16'h0020); rd(0, "R1 status"); wr(0, 16'h00FF);
    // R4 programming
    wr(16'h10, 16'h0040); wr(16'h10, 16'h12F0); rd(16'h10, "R4 status"); wr(0, 16'h00FF);
    rd(16'h10, "R4");
    wr(16'h10, 16'h0010); wr(16'h10, 16'h0F3F); wr(0, 16'h00F0); rd(16'h10, "R4 clear only");
    // R4 data FF during program, R3 masked address
    wr(16'h0104, 16'h0040); wr(16'h0104, 16'hA5FF); rd(4, "R4 ff data"); wr(0, 16'h00FF);
    rd(4, "R3 mask");
    // R2 wrong size
    wr(0, 16'h0090, 1); rd(16'h10, "R2");
    wr(16'h20, 16'h0040); wr(16'h20, 16'h0000, 1); wr(16'h20, 16'h0000, 4); rd(16'h20, "R2 prog pending");
    wr(16'h20, 16'h7E7E); wr(0, 16'h00FF); rd(16'h20, "R2 prog after");
    // R7 identifier
    wr(0, 16'h0090);
    rd(0, "R7 mfr"); rd(2, "R7 dev"); rd(4, "R7 lock"); rd(10, "R7 cfg"); rd(6, "R7 other");
    // R6 query entry
    wr(16'h54, 16'h0098); rd(2, "R6 wrong addr");
    wr(16'hAA, 16'h0098);
    rd(16'h20, "R12 Q"); rd(16'h22, "R12 R"); rd(16'h24, "R12 Y"); rd(16'h26, "R12 id");
    rd(16'h52, "R12 size"); rd(16'h5C, "R12 nreg"); rd(16'h5E, "R12 blocks");
    rd(16'h66, "R12 over"); rd(16'h1020, "R3 query mask"); rd(0, "R12 below");
    wr(0, 16'h0050); rd(16'h20, "R10 no effect in query");
    wr(0, 16'h00F0); rd(16'h10, "R5");
    // R8 erase
    wr(16'h50, 16'h0040); wr(16'h50, 16'h0000); wr(0, 16'h00FF);
    wr(16'h10, 16'h0020); rd(0, "R11 erase state");
    wr(16'h10, 16'h00D0); rd(0, "R8 status"); wr(0, 16'h00FF);
    rd(16'h10, "R8 erased"); rd(16'h50, "R8 other block");
    wr(0, 16'h0020); wr(0, 16'h0033); rd(0, "R8 error bits"); wr(0, 16'h00FF);
    rd(0, "R8 array unchanged");
    wr(16'h50, 16'h0020); wr(16'h50, 16'h00D0); rd(0, "R8 clear err"); wr(0, 16'h00FF);
    rd(16'h50, "R8 block1 erased");
    // R9 protect
    wr(0, 16'h0060); wr(0, 16'h0001); rd(0, "R9 accepted"); wr(0, 16'h00FF);
    wr(0, 16'h0060); wr(0, 16'h002F); rd(0, "R9 lockdown");
    wr(0, 16'h0050); rd(0, "R11 query status ignored clear");
    wr(0, 16'h00FF);
    wr(0, 16'h0060); wr(0, 16'h0077); rd(0, "R9 error"); wr(0, 16'h00F0);
    // R10 clear status
    wr(0, 16'h0050); rd(0, "R10 mode kept"); wr(0, 16'h0020); rd(0, "R10 cleared"); wr(0, 16'h00FF);
    rd(0, "R5 final");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule